// File: doc/BRIEF.md
# Unaligned Access Splitter for Word-Only Memory

This block sits between a requester that issues byte-addressed reads and writes of 1, 2 or 4 bytes at any byte alignment and a memory that is addressed in whole words only. That memory has no byte strobes, so it cannot write part of a word. The splitter turns each request into a short series of whole-word memory cycles. A write that covers a full word goes straight out as one write. Any write that touches only part of a word first reads that word, merges the new bytes into it and writes it back. An access that crosses a word boundary is handled as two word-sized pieces, the lower word first.

Bytes are placed little-endian. The request byte at byte address A lands in lane A mod 4 of word A div 4. Reads return the requested bytes right-justified, with unused upper bytes cleared. A read that crosses a boundary takes the upper bytes of the first word and the lower bytes of the second. The block handles one request at a time, and `req_ready` tells the requester when it may issue the next one.

Top module: `unaligned_word_bridge`

## Requirements
- R1: After reset, `req_ready` is 1 and both `mem_valid` and `resp_valid` are 0.
- R2: A write of full word width at a word-aligned address produces exactly one memory write to word address `req_addr >> 2`, with no memory read.
- R3: A write that covers only part of one word first reads that word and then writes it back. Only the lanes from `req_addr mod 4` upward, for the access size, take request bytes (request byte 0 in the lowest of those lanes). All other lanes keep their old value.
- R4: A write that crosses a word boundary produces four cycles in this order: read word W, write W, read W+1, write W+1. The low request bytes go to the upper lanes of W and the remaining bytes to the lower lanes of W+1.
- R5: A read that fits in one word produces exactly one memory read. It returns request byte i from byte address `req_addr+i` in `resp_rdata[8i+7:8i]`, and bytes beyond the access size read as zero.
- R6: A read that crosses a word boundary produces a read of W and then a read of W+1. The result joins the upper bytes of W (as the low result bytes) with the lower bytes of W+1.
- R7: `req_size` encodes the access width: 0 means 1 byte, 1 means 2 bytes, 2 means 4 bytes, and 3 is treated the same as 2.
- R8: From the cycle after a request is accepted, `req_ready` stays 0 until the last memory cycle is acknowledged. `resp_valid` is then a one-cycle pulse in the following cycle, and `req_ready` is 1 during that pulse.
- R9: While `mem_valid` is 1 and `mem_ack` is 0, the values of `mem_addr`, `mem_write` and `mem_wdata` do not change.
- R10: The second word of a boundary-crossing access is the next word address modulo the word address space, so an access at the top of memory wraps to word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Idle, request will be taken |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | Access width code (R7) |
| req_wdata | input | DATA_W | Write bytes, right-justified |
| resp_valid | output | 1 | Completion pulse |
| resp_rdata | output | DATA_W | Read result, right-justified; zero for writes |
| mem_valid | output | 1 | Memory cycle pending |
| mem_write | output | 1 | Memory cycle is a write |
| mem_addr | output | ADDR_W-2 | Word address |
| mem_wdata | output | DATA_W | Whole word to write |
| mem_ack | input | 1 | Memory cycle done, read data valid |
| mem_rdata | input | DATA_W | Word read from memory |

## Verification
The bench builds the block with a 32-bit data path and an 8-bit byte address, giving a 64-word memory. Both wrap at the top word and the full set of lane offsets are therefore within reach of a few directed accesses. The memory model stretches each cycle with configurable wait states, which exposes any change on the memory port before acknowledge. Its log of cycle order and word addresses lets the bench compare the read/write sequence of each access with the one the requirements predict.

// File: rtl/uwb_pkg.sv
package uwb_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_LO,
      ST_WR_LO,
      ST_RD_HI,
      ST_WR_HI
   } uwb_state_e;
endpackage

// File: rtl/uwb_span_calc.sv
module uwb_span_calc #(
   parameter int DATA_W = 32,
   localparam int BYTES = DATA_W / 8,
   localparam int LANE_W = $clog2(BYTES)
) (
   input  logic [LANE_W-1:0] off,
   input  logic [1:0]        size,
   input  logic [DATA_W-1:0] wdata,
   output logic [BYTES-1:0]  field_mask,
   output logic [BYTES-1:0]  lo_mask,
   output logic [BYTES-1:0]  hi_mask,
   output logic [DATA_W-1:0] lo_data,
   output logic [DATA_W-1:0] hi_data
);
   logic [LANE_W:0]         num_bytes;
   logic [2*BYTES-1:0]      wide_mask;
   logic [2*DATA_W-1:0]     wide_data;
   logic [LANE_W+2:0]       bit_shift;

   // access width in bytes, clamped to the word width
   always_comb begin
      if (int'(size) >= LANE_W) num_bytes = (LANE_W+1)'(BYTES);
      else                      num_bytes = (LANE_W+1)'(1) << size;
   end

   for (genvar i = 0; i < BYTES; i++) begin : g_field
      assign field_mask[i] = (num_bytes > (LANE_W+1)'(i));
   end

   assign bit_shift = {off, 3'b000};
   assign wide_mask = {{BYTES{1'b0}}, field_mask} << off;
   assign wide_data = {{DATA_W{1'b0}}, wdata} << bit_shift;
   assign lo_mask   = wide_mask[BYTES-1:0];
   assign hi_mask   = wide_mask[2*BYTES-1:BYTES];
   assign lo_data   = wide_data[DATA_W-1:0];
   assign hi_data   = wide_data[2*DATA_W-1:DATA_W];
endmodule

// File: rtl/uwb_lane_merge.sv
module uwb_lane_merge #(
   parameter int DATA_W = 32,
   localparam int BYTES = DATA_W / 8
) (
   input  logic [DATA_W-1:0] old_word,
   input  logic [DATA_W-1:0] new_word,
   input  logic [BYTES-1:0]  lane_sel,
   output logic [DATA_W-1:0] merged
);
   for (genvar i = 0; i < BYTES; i++) begin : g_lane
      assign merged[i*8 +: 8] = lane_sel[i] ? new_word[i*8 +: 8] : old_word[i*8 +: 8];
   end
endmodule

// File: rtl/uwb_read_align.sv
module uwb_read_align #(
   parameter int DATA_W = 32,
   localparam int BYTES = DATA_W / 8,
   localparam int LANE_W = $clog2(BYTES)
) (
   input  logic [DATA_W-1:0] lo_word,
   input  logic [DATA_W-1:0] hi_word,
   input  logic [LANE_W-1:0] off,
   input  logic [BYTES-1:0]  field_mask,
   output logic [DATA_W-1:0] aligned
);
   logic [2*DATA_W-1:0] joined;
   logic [LANE_W+2:0]   bit_shift;

   assign bit_shift = {off, 3'b000};
   assign joined    = {hi_word, lo_word} >> bit_shift;

   for (genvar i = 0; i < BYTES; i++) begin : g_lane
      assign aligned[i*8 +: 8] = field_mask[i] ? joined[i*8 +: 8] : 8'h00;
   end
endmodule

// File: rtl/unaligned_word_bridge.sv
module unaligned_word_bridge #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  req_valid,
   output logic                                  req_ready,
   input  logic                                  req_write,
   input  logic [ADDR_W-1:0]                     req_addr,
   input  logic [1:0]                            req_size,
   input  logic [DATA_W-1:0]                     req_wdata,
   output logic                                  resp_valid,
   output logic [DATA_W-1:0]                     resp_rdata,
   output logic                                  mem_valid,
   output logic                                  mem_write,
   output logic [ADDR_W-$clog2(DATA_W/8)-1:0]    mem_addr,
   output logic [DATA_W-1:0]                     mem_wdata,
   input  logic                                  mem_ack,
   input  logic [DATA_W-1:0]                     mem_rdata
);
   import uwb_pkg::*;

   localparam int BYTES   = DATA_W / 8;
   localparam int LANE_W  = $clog2(BYTES);
   localparam int WADDR_W = ADDR_W - LANE_W;

   if (!(DATA_W == 16 || DATA_W == 32 || DATA_W == 64)) begin : g_bad_width
      $error("unaligned_word_bridge: DATA_W must be 16, 32 or 64");
   end
   if (ADDR_W <= LANE_W + 1) begin : g_bad_addr
      $error("unaligned_word_bridge: ADDR_W too small for DATA_W");
   end

   uwb_state_e           state_q;
   logic [WADDR_W-1:0]   waddr_q;
   logic [LANE_W-1:0]    off_q;
   logic [BYTES-1:0]     field_q, lo_mask_q, hi_mask_q;
   logic [DATA_W-1:0]    lo_data_q, hi_data_q;
   logic                 write_q, two_q;
   logic [DATA_W-1:0]    rd_lo_q, wbuf_q;
   logic                 resp_valid_q;
   logic [DATA_W-1:0]    resp_rdata_q;

   logic [BYTES-1:0]     s_field, s_lo_mask, s_hi_mask;
   logic [DATA_W-1:0]    s_lo_data, s_hi_data;
   logic                 on_hi;
   logic [DATA_W-1:0]    merge_new, merged, aligned, align_lo;
   logic [BYTES-1:0]     merge_sel;

   uwb_span_calc #(.DATA_W(DATA_W)) u_span (
      .off        (req_addr[LANE_W-1:0]),
      .size       (req_size),
      .wdata      (req_wdata),
      .field_mask (s_field),
      .lo_mask    (s_lo_mask),
      .hi_mask    (s_hi_mask),
      .lo_data    (s_lo_data),
      .hi_data    (s_hi_data)
   );

   assign on_hi     = (state_q == ST_RD_HI) || (state_q == ST_WR_HI);
   assign merge_new = on_hi ? hi_data_q : lo_data_q;
   assign merge_sel = on_hi ? hi_mask_q : lo_mask_q;
   assign align_lo  = on_hi ? rd_lo_q : mem_rdata;

   uwb_lane_merge #(.DATA_W(DATA_W)) u_merge (
      .old_word (mem_rdata),
      .new_word (merge_new),
      .lane_sel (merge_sel),
      .merged   (merged)
   );

   uwb_read_align #(.DATA_W(DATA_W)) u_align (
      .lo_word    (align_lo),
      .hi_word    (mem_rdata),
      .off        (off_q),
      .field_mask (field_q),
      .aligned    (aligned)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         waddr_q      <= '0;
         off_q        <= '0;
         field_q      <= '0;
         lo_mask_q    <= '0;
         hi_mask_q    <= '0;
         lo_data_q    <= '0;
         hi_data_q    <= '0;
         write_q      <= 1'b0;
         two_q        <= 1'b0;
         rd_lo_q      <= '0;
         wbuf_q       <= '0;
         resp_valid_q <= 1'b0;
         resp_rdata_q <= '0;
      end else begin
         resp_valid_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  waddr_q   <= req_addr[ADDR_W-1:LANE_W];
                  off_q     <= req_addr[LANE_W-1:0];
                  field_q   <= s_field;
                  lo_mask_q <= s_lo_mask;
                  hi_mask_q <= s_hi_mask;
                  lo_data_q <= s_lo_data;
                  hi_data_q <= s_hi_data;
                  write_q   <= req_write;
                  two_q     <= |s_hi_mask;
                  if (req_write && (&s_lo_mask)) begin
                     wbuf_q  <= s_lo_data;
                     state_q <= ST_WR_LO;
                  end else begin
                     state_q <= ST_RD_LO;
                  end
               end
            end
            ST_RD_LO: begin
               if (mem_ack) begin
                  rd_lo_q <= mem_rdata;
                  if (write_q) begin
                     wbuf_q  <= merged;
                     state_q <= ST_WR_LO;
                  end else if (two_q) begin
                     state_q <= ST_RD_HI;
                  end else begin
                     resp_valid_q <= 1'b1;
                     resp_rdata_q <= aligned;
                     state_q      <= ST_IDLE;
                  end
               end
            end
            ST_WR_LO: begin
               if (mem_ack) begin
                  if (two_q) begin
                     state_q <= ST_RD_HI;
                  end else begin
                     resp_valid_q <= 1'b1;
                     resp_rdata_q <= '0;
                     state_q      <= ST_IDLE;
                  end
               end
            end
            ST_RD_HI: begin
               if (mem_ack) begin
                  if (write_q) begin
                     wbuf_q  <= merged;
                     state_q <= ST_WR_HI;
                  end else begin
                     resp_valid_q <= 1'b1;
                     resp_rdata_q <= aligned;
                     state_q      <= ST_IDLE;
                  end
               end
            end
            ST_WR_HI: begin
               if (mem_ack) begin
                  resp_valid_q <= 1'b1;
                  resp_rdata_q <= '0;
                  state_q      <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready  = (state_q == ST_IDLE);
   assign resp_valid = resp_valid_q;
   assign resp_rdata = resp_rdata_q;
   assign mem_valid  = (state_q != ST_IDLE);
   assign mem_write  = (state_q == ST_WR_LO) || (state_q == ST_WR_HI);
   assign mem_addr   = on_hi ? waddr_q + 1'b1 : waddr_q;
   assign mem_wdata  = wbuf_q;

   // R1
   reset_idle_chk: assert property (@(posedge clk) $fell(rst_n) |=> req_ready && !mem_valid && !resp_valid);

   // R9
   bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid && !mem_ack |=> mem_valid && $stable(mem_addr) && $stable(mem_write) && $stable(mem_wdata));

   // R8
   busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> !req_ready);

   // R8
   resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |=> !resp_valid);

   // R8
   resp_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |-> req_ready);

   // R2
   full_write_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready && req_write && (req_addr[LANE_W-1:0] == '0) && (req_size >= 2'(LANE_W))
      |=> mem_valid && mem_write);

   // R3
   partial_write_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready && req_write && ((req_addr[LANE_W-1:0] != '0) || (req_size < 2'(LANE_W)))
      |=> mem_valid && !mem_write);

   // R5
   read_starts_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready && !req_write |=> mem_valid && !mem_write);
endmodule

// File: tb/unaligned_word_bridge_bench.sv
module unaligned_word_bridge_bench;
   localparam int AW = 8;
   localparam int DW = 32;
   localparam int NW = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [1:0]  req_size = '0;
   logic [DW-1:0] req_wdata = '0;
   logic        req_ready, resp_valid;
   logic [DW-1:0] resp_rdata;
   logic        mem_valid, mem_write;
   logic [5:0]  mem_addr;
   logic [DW-1:0] mem_wdata;
   logic        mem_ack;
   logic [DW-1:0] mem_rdata;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2 clk = ~clk;

   unaligned_word_bridge #(.ADDR_W(AW), .DATA_W(DW)) u_unaligned_word_bridge (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
      .resp_valid(resp_valid), .resp_rdata(resp_rdata),
      .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
   );

   // memory model with wait states and a cycle log
   logic [DW-1:0] mem [NW];
   logic [DW-1:0] refm [NW];
   int  wait_set = 1;
   int  wait_cnt;
   int  nops;
   bit  log_wr [256];
   int  log_addr [256];
   bit  unstable;
   logic [5:0] hold_addr;
   logic hold_wr;
   logic [DW-1:0] hold_wd;

   function automatic logic [DW-1:0] init_word(int i);
      return 32'h11223344 ^ (32'(i) * 32'h01030507);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         mem_ack   <= 1'b0;
         mem_rdata <= '0;
         wait_cnt  <= 0;
         nops      <= 0;
         unstable  <= 1'b0;
         for (int i = 0; i < NW; i++) mem[i] <= init_word(i);
      end else if (mem_ack) begin
         mem_ack  <= 1'b0;
         wait_cnt <= 0;
      end else if (mem_valid) begin
         if (wait_cnt > 0 && (mem_addr != hold_addr || mem_write != hold_wr || mem_wdata != hold_wd))
            unstable <= 1'b1;
         hold_addr <= mem_addr;
         hold_wr   <= mem_write;
         hold_wd   <= mem_wdata;
         if (wait_cnt >= wait_set) begin
            mem_ack <= 1'b1;
            mem_rdata <= mem[mem_addr];
            if (mem_write) mem[mem_addr] <= mem_wdata;
            log_wr[nops & 255]   <= mem_write;
            log_addr[nops & 255] <= int'(mem_addr);
            nops <= nops + 1;
         end else begin
            wait_cnt <= wait_cnt + 1;
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic int nbytes(logic [1:0] sz);
      return (sz >= 2) ? 4 : (1 << sz);
   endfunction

   function automatic logic [7:0] ref_byte(int a);
      int b = a & 255;
      return refm[b / 4][(b % 4) * 8 +: 8];
   endfunction

   task automatic ref_write(input int a, input logic [1:0] sz, input logic [DW-1:0] wd);
      for (int i = 0; i < nbytes(sz); i++) begin
         int b = (a + i) & 255;
         refm[b / 4][(b % 4) * 8 +: 8] = wd[i * 8 +: 8];
      end
   endtask

   function automatic logic [DW-1:0] ref_read(int a, logic [1:0] sz);
      logic [DW-1:0] r = '0;
      for (int i = 0; i < nbytes(sz); i++) r[i * 8 +: 8] = ref_byte(a + i);
      return r;
   endfunction

   // one request through the handshake, R8 checked on every access
   task automatic access(input bit wr, input int a, input logic [1:0] sz,
                         input logic [DW-1:0] wd, output logic [DW-1:0] rd);
      bit busy_bad = 0;
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = AW'(a); req_size = sz; req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0;
      while (!resp_valid) begin
         if (req_ready) busy_bad = 1;
         @(negedge clk);
      end
      rd = resp_rdata;
      chk(!busy_bad && req_ready, "R8 ready low while busy, high at response",
          {30'b0, busy_bad, req_ready}, 32'h1);
      @(negedge clk);
      chk(!resp_valid, "R8 response is one cycle", {31'b0, resp_valid}, 32'h0);
      if (wr) ref_write(a, sz, wd);
   endtask

   task automatic chk_op(input int base, input int k, input bit wr, input int wa, input string tag);
      chk(log_wr[(base + k) & 255] == wr && log_addr[(base + k) & 255] == wa, tag,
          {log_wr[(base + k) & 255], 7'b0, 24'(log_addr[(base + k) & 255])},
          {wr, 7'b0, 24'(wa)});
   endtask

   task automatic t_reset;
      chk(req_ready && !mem_valid && !resp_valid, "R1 reset state",
          {29'b0, req_ready, mem_valid, resp_valid}, 32'h4);
   endtask

   task automatic t_aligned_write;
      logic [DW-1:0] rd;
      int base = nops;
      access(1, 8'h10, 2'd2, 32'hCAFE_F00D, rd);
      chk(nops - base == 1, "R2 one bus cycle", 32'(nops - base), 32'd1);
      chk_op(base, 0, 1, 4, "R2 single write to word 4");
      chk(mem[4] == refm[4], "R2 word contents", mem[4], refm[4]);
   endtask

   task automatic t_partial_write;
      logic [DW-1:0] rd;
      int base = nops;
      access(1, 8'h21, 2'd0, 32'h0000_00A5, rd);
      chk(nops - base == 2, "R3 byte write cycle count", 32'(nops - base), 32'd2);
      chk_op(base, 0, 0, 8, "R3 read first");
      chk_op(base, 1, 1, 8, "R3 then write");
      chk(mem[8] == refm[8], "R3 byte lane 1 merge", mem[8], refm[8]);
      base = nops;
      access(1, 8'h26, 2'd1, 32'h0000_BEEF, rd);
      chk(nops - base == 2, "R3 half write cycle count", 32'(nops - base), 32'd2);
      chk(mem[9] == refm[9], "R3 half lanes 2-3 merge", mem[9], refm[9]);
   endtask

   task automatic t_span_write;
      logic [DW-1:0] rd;
      int base = nops;
      access(1, 8'h32, 2'd2, 32'h4433_2211, rd);
      chk(nops - base == 4, "R4 four bus cycles", 32'(nops - base), 32'd4);
      chk_op(base, 0, 0, 12, "R4 op0 read W");
      chk_op(base, 1, 1, 12, "R4 op1 write W");
      chk_op(base, 2, 0, 13, "R4 op2 read W+1");
      chk_op(base, 3, 1, 13, "R4 op3 write W+1");
      chk(mem[12] == refm[12], "R4 first word", mem[12], refm[12]);
      chk(mem[13] == refm[13], "R4 second word", mem[13], refm[13]);
      access(1, 8'h37, 2'd3, 32'h8877_6655, rd);
      chk(mem[13] == refm[13] && mem[14] == refm[14], "R7 size 3 writes 4 bytes",
          mem[14], refm[14]);
   endtask

   task automatic t_single_read;
      logic [DW-1:0] rd;
      int base = nops;
      access(0, 8'h21, 2'd0, '0, rd);
      chk(nops - base == 1, "R5 one read", 32'(nops - base), 32'd1);
      chk(rd == ref_read(8'h21, 2'd0), "R5 byte read", rd, ref_read(8'h21, 2'd0));
      access(0, 8'h26, 2'd1, '0, rd);
      chk(rd == ref_read(8'h26, 2'd1), "R5 half read", rd, ref_read(8'h26, 2'd1));
      access(0, 8'h10, 2'd2, '0, rd);
      chk(rd == ref_read(8'h10, 2'd2), "R5 aligned word read", rd, ref_read(8'h10, 2'd2));
      access(0, 8'h05, 2'd0, '0, rd);
      chk(rd == ref_read(8'h05, 2'd0), "R5 untouched byte", rd, ref_read(8'h05, 2'd0));
   endtask

   task automatic t_span_read;
      logic [DW-1:0] rd;
      int base = nops;
      access(0, 8'h31, 2'd2, '0, rd);
      chk(nops - base == 2, "R6 two reads", 32'(nops - base), 32'd2);
      chk_op(base, 0, 0, 12, "R6 read W first");
      chk_op(base, 1, 0, 13, "R6 read W+1 second");
      chk(rd == ref_read(8'h31, 2'd2), "R6 joined word", rd, ref_read(8'h31, 2'd2));
      access(0, 8'h17, 2'd1, '0, rd);
      chk(rd == ref_read(8'h17, 2'd1), "R6 half across boundary", rd, ref_read(8'h17, 2'd1));
      access(0, 8'h31, 2'd3, '0, rd);
      chk(rd == ref_read(8'h31, 2'd2), "R7 size 3 reads 4 bytes", rd, ref_read(8'h31, 2'd2));
   endtask

   task automatic t_wrap;
      logic [DW-1:0] rd;
      int base = nops;
      access(1, 8'hFE, 2'd2, 32'hD00D_1EAF, rd);
      chk_op(base, 1, 1, 63, "R10 first word at top");
      chk_op(base, 3, 1, 0, "R10 second word wraps to 0");
      chk(mem[63] == refm[63] && mem[0] == refm[0], "R10 wrapped contents", mem[0], refm[0]);
      access(0, 8'hFD, 2'd2, '0, rd);
      chk(rd == ref_read(8'hFD, 2'd2), "R10 wrapped read", rd, ref_read(8'hFD, 2'd2));
   endtask

   task automatic t_hold;
      logic [DW-1:0] rd;
      wait_set = 3;
      access(1, 8'h43, 2'd1, 32'h0000_7E57, rd);
      access(0, 8'h42, 2'd2, '0, rd);
      chk(rd == ref_read(8'h42, 2'd2), "R9 data under wait states", rd, ref_read(8'h42, 2'd2));
      chk(!unstable, "R9 bus stable until ack", {31'b0, unstable}, 32'h0);
      wait_set = 0;
      access(1, 8'h45, 2'd0, 32'h0000_0033, rd);
      chk(mem[17] == refm[17], "R3 merge with no wait", mem[17], refm[17]);
   endtask

   initial begin
      for (int i = 0; i < NW; i++) refm[i] = init_word(i);
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_aligned_write();
      t_partial_write();
      t_span_write();
      t_single_read();
      t_span_read();
      t_wrap();
      t_hold();
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule